// File: doc/BRIEF.md
# Backplane Window Core Switcher

This block stands between a host register-access port and a backplane that is reached through one movable address window. Each host request names a target core, a byte offset inside that core's region, an access width and a direction. When the target core is not the one the window currently maps, the block first moves the window. It writes the window base register, reads the register back, and accepts the new mapping only when the value it reads back decodes to the requested core.

When the read-back does not match, the block waits a fixed delay of about 10 microseconds and tries again. After a bounded number of attempts it gives up. It then raises a one-cycle error pulse and a sticky error flag. The failed read completes with all ones at the access width, and a failed write is dropped. A powered-down bus gives the same all-ones and dropped-write behaviour, but the block does not touch the window in that case.

The host uses a valid/ready request and a single-cycle response pulse. Only one request is handled at a time, and the requester is stalled for the whole window sequence. The region size is a power of two, so converting the read-back value to a core index takes a subtraction and a shift.

Top module: `bwcs_core_switch`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid, win_wr_en, win_rd_en, bp_valid, err_pulse and err_sticky are 0, and no core is recorded as mapped: the first request to any core performs a window write.
- R2: When win_wr_en is high, win_wr_data equals ENUM_BASE + core * 2^REGION_SHIFT for the requested core. Every window write is followed on the next cycle by a window read (win_rd_en), and win_rd_data is taken one cycle after win_rd_en.
- R3: A read-back value is accepted only if (value - ENUM_BASE) has its low REGION_SHIFT bits zero, decodes to an index below NUM_CORES, and that index equals the requested core. Misaligned values and out-of-range aliases count as mismatches.
- R4: After a mismatch the block waits DELAY_CYC = CLK_MHZ * DELAY_US cycles and then writes the window again. Consecutive window writes within one switch are exactly DELAY_CYC + 3 cycles apart.
- R5: A switch fails after MAX_RETRY + 2 mismatching attempts. The failure raises err_pulse for one cycle, coinciding with rsp_valid, and sets err_sticky, which stays at 1 until reset.
- R6: No window write takes place when the requested core equals the recorded mapped core. A successful switch records the new core, and a failed switch clears the record.
- R7: After a failed switch, a read returns all ones at the access width, zero-extended (size code 0 gives 0x000000FF, 1 gives 0x0000FFFF, 2 gives 0xFFFFFFFF). A write issues no backplane transfer.
- R8: When bus_pwr_ok is 0 at request acceptance, the request completes with the R7 error result, performs no window write and raises no err_pulse.
- R9: A normal access holds bp_valid, with bp_addr, bp_size, bp_write and bp_wdata taken from the request, until bp_ready. Read data is bp_rdata masked to the access width (size code 0 byte, 1 half-word, 2 word).
- R10: req_ready is high only when the block is idle, so the requester is stalled during a switch. Each accepted request produces exactly one single-cycle rsp_valid pulse, and writes respond with rsp_rdata 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_pwr_ok | input | 1 | Backplane powered; 0 turns requests into error results |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block idle and accepting a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access width: 0 byte, 1 half-word, 2 word |
| req_core | input | IDX_W | Target core index |
| req_offset | input | OFF_W | Byte offset within the core region |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 32 | Read result (0 for writes) |
| win_wr_en | output | 1 | Window base register write strobe |
| win_wr_data | output | 32 | Window base value |
| win_rd_en | output | 1 | Window base register read strobe |
| win_rd_data | input | 32 | Read-back value, valid the cycle after win_rd_en |
| bp_valid | output | 1 | Backplane transfer request |
| bp_write | output | 1 | Backplane transfer direction |
| bp_size | output | 2 | Backplane transfer width |
| bp_addr | output | OFF_W | Backplane offset through the window |
| bp_wdata | output | 32 | Backplane write data |
| bp_ready | input | 1 | Backplane transfer completes |
| bp_rdata | input | 32 | Backplane read data, valid with bp_ready |
| err_pulse | output | 1 | One-cycle pulse on a failed switch |
| err_sticky | output | 1 | Set by a failed switch, cleared by reset |

## Verification
The embedded properties watch the protocol shape on every cycle. They check that a read strobe follows each window write, that the write value is aligned to a region, that the attempt counter stays within its bound, and that the delay counter stays in range. They also check that the backplane request holds steady until it completes, that responses and error pulses are single cycles, that the sticky flag only ever stays set, and that a failed switch is never followed by a backplane transfer.

Only the bench scenarios can show the data-dependent outcomes. These are the exact retry spacing, and whether misaligned or aliased read-backs are rejected. They also include the number of window writes a request costs given the mapping history, the all-ones masking at each width, dropped writes, the power-down path and the mapping record being cleared after a failure or a reset.

// File: rtl/bwcs_pkg.sv
// Shared types and helpers for the backplane window core switcher.
// Assumes access widths are coded 0 = byte, 1 = half-word, 2 = word;
// code 3 is treated as a word.
package bwcs_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WIN_WR  = 3'd1,
        ST_WIN_RD  = 3'd2,
        ST_WIN_CHK = 3'd3,
        ST_WAIT    = 3'd4,
        ST_ACCESS  = 3'd5,
        ST_RESP    = 3'd6
    } sw_state_e;

    // Lane mask for an access width code.
    function automatic logic [31:0] size_mask(input logic [1:0] sz);
        logic [31:0] m;
        case (sz)
            SZ_BYTE: m = 32'h0000_00FF;
            SZ_HALF: m = 32'h0000_FFFF;
            default: m = 32'hFFFF_FFFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/bwcs_delay_timer.sv
// Retry delay timer: after a one-cycle start, done rises once
// DELAY_CYC cycles later and then the timer goes idle.
// Assumes DELAY_CYC >= 1 and start is not given while running.
module bwcs_delay_timer #(
    parameter int unsigned DELAY_CYC = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int unsigned CW = (DELAY_CYC < 2) ? 1 : $clog2(DELAY_CYC);
    localparam logic [CW-1:0] LOAD = CW'(DELAY_CYC - 1);

    logic [CW-1:0] cnt;
    logic          running;

    // Load on start, count down while running, stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (start) begin
            cnt     <= LOAD;
            running <= 1'b1;
        end else if (running) begin
            if (cnt == '0) running <= 1'b0;
            else           cnt     <= cnt - 1'b1;
        end
    end

    assign done = running && (cnt == '0);

    // R4: the count never leaves its loaded range
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt <= LOAD));

    // R4: a fresh start never reports done in the following cycle unless the delay is one
    p_no_early_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (DELAY_CYC > 1)) |=> !done);

endmodule

// File: rtl/bwcs_win_codec.sv
// Window value encoder and read-back matcher.
// The encoder forms base plus index times the power-of-two region size.
// The matcher accepts a read-back only if it is aligned, in range and
// equal to the wanted index. Purely combinational.
module bwcs_win_codec #(
    parameter int unsigned NUM_CORES    = 16,
    parameter int unsigned IDX_W        = 4,
    parameter int unsigned REGION_SHIFT = 12,
    parameter logic [31:0] ENUM_BASE    = 32'h1800_0000
) (
    input  logic [IDX_W-1:0] want_idx,
    input  logic [31:0]      rb_value,
    output logic [31:0]      win_value,
    output logic             match
);
    logic [31:0] diff;
    logic [31:0] idx_full;
    logic        aligned;
    logic        in_range;

    // Encode: base + (index << shift).
    always_comb begin
        win_value = ENUM_BASE + ({{(32-IDX_W){1'b0}}, want_idx} << REGION_SHIFT);
    end

    // Decode: subtract base, check alignment and range, compare index.
    always_comb begin
        diff     = rb_value - ENUM_BASE;
        aligned  = (diff[REGION_SHIFT-1:0] == '0);
        idx_full = diff >> REGION_SHIFT;
        in_range = (idx_full < 32'(NUM_CORES));
        match    = aligned && in_range && (idx_full[IDX_W-1:0] == want_idx);
    end

endmodule

// File: rtl/bwcs_rsp_lane.sv
// Response data shaper: masks read data to the access width, replaces
// it by all ones at that width on error, and returns zero for writes.
module bwcs_rsp_lane
    import bwcs_pkg::*;
(
    input  logic [1:0]  size,
    input  logic        is_err,
    input  logic        is_write,
    input  logic [31:0] raw,
    output logic [31:0] rdata
);
    logic [31:0] mask;

    // Select the response word for the finished access.
    always_comb begin
        mask = size_mask(size);
        if (is_write)    rdata = 32'h0;
        else if (is_err) rdata = mask;
        else             rdata = raw & mask;
    end

endmodule

// File: rtl/bwcs_core_switch.sv
// Backplane window core switcher (top).
// Accepts one host request at a time. If the target core is not the
// recorded mapped core, it programs the window, reads it back and
// retries after a timed delay, up to MAX_RETRY+2 attempts. It then
// performs the backplane access or returns an all-ones error result.
// Assumes win_rd_data is valid one cycle after win_rd_en, and that
// bp_ready completes a transfer held by bp_valid.
module bwcs_core_switch
    import bwcs_pkg::*;
#(
    parameter int unsigned NUM_CORES    = 16,
    parameter int unsigned REGION_SHIFT = 12,
    parameter logic [31:0] ENUM_BASE    = 32'h1800_0000,
    parameter int unsigned OFF_W        = 12,
    parameter int unsigned MAX_RETRY    = 2,
    parameter int unsigned CLK_MHZ      = 50,
    parameter int unsigned DELAY_US     = 10,
    localparam int unsigned IDX_W       = (NUM_CORES < 2) ? 1 : $clog2(NUM_CORES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_pwr_ok,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [IDX_W-1:0]  req_core,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              win_wr_en,
    output logic [31:0]       win_wr_data,
    output logic              win_rd_en,
    input  logic [31:0]       win_rd_data,
    output logic              bp_valid,
    output logic              bp_write,
    output logic [1:0]        bp_size,
    output logic [OFF_W-1:0]  bp_addr,
    output logic [31:0]       bp_wdata,
    input  logic              bp_ready,
    input  logic [31:0]       bp_rdata,
    output logic              err_pulse,
    output logic              err_sticky
);
    localparam int unsigned DELAY_CYC = CLK_MHZ * DELAY_US;
    localparam int unsigned ATT_W     = $clog2(MAX_RETRY + 3);
    localparam logic [ATT_W-1:0] ATT_LAST = ATT_W'(MAX_RETRY + 1);

    sw_state_e         state, state_d;
    logic              r_write;
    logic [1:0]        r_size;
    logic [IDX_W-1:0]  r_core;
    logic [OFF_W-1:0]  r_off;
    logic [31:0]       r_wdata;
    logic              map_valid;
    logic [IDX_W-1:0]  map_idx;
    logic [ATT_W-1:0]  attempts;
    logic              resp_err;
    logic [31:0]       raw_q;
    logic              rb_match;
    logic              timer_start;
    logic              timer_done;
    logic [31:0]       enc_value;
    logic              accept;
    logic              hit;
    logic              give_up;

    bwcs_win_codec #(
        .NUM_CORES   (NUM_CORES),
        .IDX_W       (IDX_W),
        .REGION_SHIFT(REGION_SHIFT),
        .ENUM_BASE   (ENUM_BASE)
    ) u_codec (
        .want_idx (r_core),
        .rb_value (win_rd_data),
        .win_value(enc_value),
        .match    (rb_match)
    );

    bwcs_delay_timer #(
        .DELAY_CYC(DELAY_CYC)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(timer_start),
        .done (timer_done)
    );

    bwcs_rsp_lane u_lane (
        .size    (r_size),
        .is_err  (resp_err),
        .is_write(r_write),
        .raw     (raw_q),
        .rdata   (rsp_rdata)
    );

    // Request acceptance, mapping hit and give-up decisions.
    always_comb begin
        accept      = (state == ST_IDLE) && req_valid;
        hit         = map_valid && (map_idx == req_core);
        give_up     = (state == ST_WIN_CHK) && !rb_match && (attempts >= ATT_LAST);
        timer_start = (state == ST_WIN_CHK) && !rb_match && !give_up;
    end

    // Next-state selection for the switch sequence.
    always_comb begin
        state_d = state;
        case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!bus_pwr_ok) state_d = ST_RESP;
                    else if (hit)    state_d = ST_ACCESS;
                    else             state_d = ST_WIN_WR;
                end
            end
            ST_WIN_WR:  state_d = ST_WIN_RD;
            ST_WIN_RD:  state_d = ST_WIN_CHK;
            ST_WIN_CHK: begin
                if (rb_match)     state_d = ST_ACCESS;
                else if (give_up) state_d = ST_RESP;
                else              state_d = ST_WAIT;
            end
            ST_WAIT:    if (timer_done) state_d = ST_WIN_WR;
            ST_ACCESS:  if (bp_ready)   state_d = ST_RESP;
            ST_RESP:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // Latch the request fields at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_write <= 1'b0;
            r_size  <= SZ_WORD;
            r_core  <= '0;
            r_off   <= '0;
            r_wdata <= '0;
        end else if (accept) begin
            r_write <= req_write;
            r_size  <= req_size;
            r_core  <= req_core;
            r_off   <= req_offset;
            r_wdata <= req_wdata;
        end
    end

    // Attempt counter: cleared per request, bumped per retry.
    always_ff @(posedge clk) begin
        if (!rst_n)           attempts <= '0;
        else if (accept)      attempts <= '0;
        else if (timer_start) attempts <= attempts + 1'b1;
    end

    // Mapped-core record: set on a confirmed switch, cleared on failure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_valid <= 1'b0;
            map_idx   <= '0;
        end else if ((state == ST_WIN_CHK) && rb_match) begin
            map_valid <= 1'b1;
            map_idx   <= r_core;
        end else if (give_up) begin
            map_valid <= 1'b0;
        end
    end

    // Response error marker: power-down or failed switch.
    always_ff @(posedge clk) begin
        if (!rst_n)       resp_err <= 1'b0;
        else if (accept)  resp_err <= !bus_pwr_ok;
        else if (give_up) resp_err <= 1'b1;
    end

    // Capture backplane read data when the transfer completes.
    always_ff @(posedge clk) begin
        if (!rst_n)                                raw_q <= '0;
        else if ((state == ST_ACCESS) && bp_ready) raw_q <= bp_rdata;
    end

    // Error reporting: one-cycle pulse and a sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_pulse  <= 1'b0;
            err_sticky <= 1'b0;
        end else begin
            err_pulse <= give_up;
            if (give_up) err_sticky <= 1'b1;
        end
    end

    // Output decode from the state.
    always_comb begin
        req_ready   = (state == ST_IDLE);
        rsp_valid   = (state == ST_RESP);
        win_wr_en   = (state == ST_WIN_WR);
        win_wr_data = enc_value;
        win_rd_en   = (state == ST_WIN_RD);
        bp_valid    = (state == ST_ACCESS);
        bp_write    = r_write;
        bp_size     = r_size;
        bp_addr     = r_off;
        bp_wdata    = r_wdata;
    end

    // R2: every window write is followed by a read-back
    p_rdback_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        win_wr_en |=> win_rd_en);

    // R2: the window value always sits on a region boundary
    p_win_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        win_wr_en |-> ((win_wr_data - ENUM_BASE) & ((32'h1 << REGION_SHIFT) - 32'h1)) == 32'h0);

    // R5: the attempt count never passes its limit
    p_attempt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        attempts <= ATT_LAST);

    // R5: the error pulse coincides with the response and lasts one cycle
    p_err_with_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (rsp_valid && err_sticky));

    // R5: the sticky flag never clears outside reset
    p_sticky_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);

    // R7: a failed switch is never followed by a backplane transfer
    p_no_bp_after_fail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> !bp_valid);

    // R9: a pending backplane transfer holds its fields steady
    p_bp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_valid && !bp_ready) |=> (bp_valid && $stable(bp_addr) && $stable(bp_wdata)));

    // R10: each response is a single cycle and returns to idle
    p_rsp_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

endmodule

// File: tb/bwcs_core_switch_test.sv
module bwcs_core_switch_test;

    localparam int unsigned DELAY   = 500;
    localparam logic [31:0] BASE    = 32'h1800_0000;
    localparam int unsigned SHIFT   = 12;
    localparam int unsigned NCORES  = 16;

    typedef struct packed {
        logic        pwr;
        logic        wr;
        logic [1:0]  sz;
        logic [3:0]  core;
        logic [11:0] off;
        logic [31:0] wdata;
        logic [3:0]  nfail;
        logic        fmode;
        logic [3:0]  wwr;
        logic        err;
    } vec_t;

    // pwr wr sz core off wdata nfail fmode exp_window_writes exp_err
    localparam vec_t TBL [13] = '{
        '{1'b1, 1'b0, 2'd2, 4'd3, 12'h010, 32'h0,         4'd0, 1'b0, 4'd1, 1'b0},
        '{1'b1, 1'b0, 2'd0, 4'd3, 12'h021, 32'h0,         4'd0, 1'b0, 4'd0, 1'b0},
        '{1'b1, 1'b0, 2'd1, 4'd3, 12'h0F2, 32'h0,         4'd0, 1'b0, 4'd0, 1'b0},
        '{1'b1, 1'b1, 2'd2, 4'd5, 12'h100, 32'hDEADBEEF,  4'd0, 1'b0, 4'd1, 1'b0},
        '{1'b1, 1'b0, 2'd2, 4'd5, 12'h104, 32'h0,         4'd0, 1'b0, 4'd0, 1'b0},
        '{1'b1, 1'b0, 2'd2, 4'd7, 12'h200, 32'h0,         4'd2, 1'b1, 4'd3, 1'b0},
        '{1'b1, 1'b0, 2'd1, 4'd9, 12'h300, 32'h0,         4'd4, 1'b0, 4'd4, 1'b1},
        '{1'b1, 1'b0, 2'd2, 4'd7, 12'h204, 32'h0,         4'd0, 1'b0, 4'd1, 1'b0},
        '{1'b1, 1'b1, 2'd0, 4'd7, 12'h3FF, 32'h12345678,  4'd5, 1'b0, 4'd0, 1'b0},
        '{1'b1, 1'b1, 2'd2, 4'd2, 12'h010, 32'hCAFEF00D,  4'd9, 1'b1, 4'd4, 1'b1},
        '{1'b0, 1'b0, 2'd2, 4'd2, 12'h010, 32'h0,         4'd0, 1'b0, 4'd0, 1'b0},
        '{1'b0, 1'b1, 2'd1, 4'd2, 12'h020, 32'hAAAA5555,  4'd0, 1'b0, 4'd0, 1'b0},
        '{1'b1, 1'b0, 2'd0, 4'd2, 12'h0AB, 32'h0,         4'd0, 1'b0, 4'd1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_pwr_ok = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [3:0]  req_core = 4'd0;
    logic [11:0] req_offset = 12'h0;
    logic [31:0] req_wdata = 32'h0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        win_wr_en;
    logic [31:0] win_wr_data;
    logic        win_rd_en;
    logic [31:0] win_rd_data = 32'h0;
    logic        bp_valid;
    logic        bp_write;
    logic [1:0]  bp_size;
    logic [11:0] bp_addr;
    logic [31:0] bp_wdata;
    logic        bp_ready = 1'b0;
    logic [31:0] bp_rdata;
    logic        err_pulse;
    logic        err_sticky;

    int n_chk = 0;
    int n_fail = 0;

    // Bench-side models and monitors.
    logic [31:0] win_reg = 32'hFFFF_FFFF;
    int          cyc = 0;
    int          wwr_cnt = 0;
    int          err_cnt = 0;
    int          bpw_cnt = 0;
    int          fail_until = 0;
    logic        fmode_q = 1'b0;
    int          last_wr_cyc = 0;
    int          gap_last = 0;
    logic [31:0] last_win_data = 32'h0;
    logic [11:0] lw_addr = 12'h0;
    logic [31:0] lw_data = 32'h0;
    logic [1:0]  lw_size = 2'd0;

    always #10 clk = ~clk;

    bwcs_core_switch uut (
        .clk(clk), .rst_n(rst_n), .bus_pwr_ok(bus_pwr_ok),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_size(req_size), .req_core(req_core), .req_offset(req_offset),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .win_wr_en(win_wr_en), .win_wr_data(win_wr_data), .win_rd_en(win_rd_en),
        .win_rd_data(win_rd_data), .bp_valid(bp_valid), .bp_write(bp_write),
        .bp_size(bp_size), .bp_addr(bp_addr), .bp_wdata(bp_wdata),
        .bp_ready(bp_ready), .bp_rdata(bp_rdata), .err_pulse(err_pulse),
        .err_sticky(err_sticky)
    );

    assign bp_rdata = 32'hC0DE_0000 ^ win_reg ^ {20'h0, bp_addr};

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (win_wr_en) begin
            wwr_cnt       <= wwr_cnt + 1;
            gap_last      <= cyc - last_wr_cyc;
            last_wr_cyc   <= cyc;
            last_win_data <= win_wr_data;
            if (wwr_cnt < fail_until)
                win_reg <= fmode_q ? (win_wr_data + (32'(NCORES) << SHIFT)) : (win_wr_data + 32'h4);
            else
                win_reg <= win_wr_data;
        end
        if (win_rd_en) win_rd_data <= win_reg;
        bp_ready <= bp_valid && !bp_ready;
        if (bp_valid && bp_ready && bp_write) begin
            bpw_cnt <= bpw_cnt + 1;
            lw_addr <= bp_addr;
            lw_data <= bp_wdata;
            lw_size <= bp_size;
        end
        if (err_pulse) err_cnt <= err_cnt + 1;
    end

    function automatic logic [31:0] wmask(input logic [1:0] sz);
        return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] win_of(input logic [3:0] core);
        return BASE + ({28'h0, core} << SHIFT);
    endfunction

    task automatic chk(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", what, act, exp);
        end
    endtask

    // Issue one request, wait for its response, return the data.
    task automatic issue(input vec_t v, output logic [31:0] got, output logic seen);
        int t;
        bus_pwr_ok = v.pwr;
        fail_until = wwr_cnt + int'(v.nfail);
        fmode_q    = v.fmode;
        @(negedge clk);
        req_valid  = 1'b1;
        req_write  = v.wr;
        req_size   = v.sz;
        req_core   = v.core;
        req_offset = v.off;
        req_wdata  = v.wdata;
        @(negedge clk);
        req_valid = 1'b0;
        t = 0;
        while (!rsp_valid && t < 5000) begin
            @(negedge clk);
            t++;
        end
        seen = rsp_valid;
        got  = rsp_rdata;
        if (!seen) begin
            n_chk++;
            n_fail++;
            $display("FAIL R10 watchdog: no response within %0d cycles", t);
        end
        @(negedge clk);
        chk(!rsp_valid, "R10 single response pulse", {31'h0, rsp_valid}, 32'h0);
    endtask

    task automatic run_vec(input vec_t v, input int idx, input logic sticky_exp);
        int w0, e0, b0;
        logic [31:0] got, exp;
        logic seen, dropped;
        w0 = wwr_cnt; e0 = err_cnt; b0 = bpw_cnt;
        issue(v, got, seen);
        dropped = v.err || !v.pwr;
        if (v.wr)         exp = 32'h0;
        else if (dropped) exp = wmask(v.sz);
        else              exp = wmask(v.sz) & (32'hC0DE_0000 ^ win_of(v.core) ^ {20'h0, v.off});
        chk(got == exp, $sformatf("R9/R7 row %0d read data", idx), got, exp);
        chk(wwr_cnt - w0 == int'(v.wwr), $sformatf("R6/R3/R8 row %0d window writes", idx),
            32'(wwr_cnt - w0), 32'(v.wwr));
        chk(err_cnt - e0 == (v.err ? 1 : 0), $sformatf("R5 row %0d error pulse", idx),
            32'(err_cnt - e0), v.err ? 32'h1 : 32'h0);
        chk(err_sticky == sticky_exp, $sformatf("R5 row %0d sticky flag", idx),
            {31'h0, err_sticky}, {31'h0, sticky_exp});
        chk(bpw_cnt - b0 == ((v.wr && !dropped) ? 1 : 0), $sformatf("R7 row %0d backplane writes", idx),
            32'(bpw_cnt - b0), (v.wr && !dropped) ? 32'h1 : 32'h0);
        if (v.wr && !dropped) begin
            chk(lw_data == v.wdata && lw_addr == v.off && lw_size == v.sz,
                $sformatf("R9 row %0d write fields", idx), lw_data, v.wdata);
        end
        if (v.wwr != 0 && !v.err) begin
            chk(last_win_data == win_of(v.core), $sformatf("R2 row %0d window value", idx),
                last_win_data, win_of(v.core));
        end
        if (v.wwr >= 2) begin
            chk(gap_last == int'(DELAY) + 3, $sformatf("R4 row %0d retry spacing", idx),
                32'(gap_last), 32'(DELAY + 3));
        end
    endtask

    initial begin
        vec_t d;
        logic [31:0] got;
        logic seen, sticky;
        int w0;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready && !rsp_valid && !win_wr_en && !win_rd_en && !bp_valid && !err_pulse && !err_sticky,
            "R1 reset outputs", {26'h0, req_ready, rsp_valid, win_wr_en, bp_valid, err_pulse, err_sticky},
            32'h20);
        rst_n = 1'b1;
        @(negedge clk);

        sticky = 1'b0;
        for (int i = 0; i < 13; i++) begin
            if (TBL[i].err) sticky = 1'b1;
            run_vec(TBL[i], i, sticky);
        end

        // R10: requester stalled during a retrying switch
        d = '{1'b1, 1'b0, 2'd2, 4'd4, 12'h044, 32'h0, 4'd2, 1'b0, 4'd3, 1'b0};
        bus_pwr_ok = 1'b1;
        fail_until = wwr_cnt + 2;
        fmode_q    = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_size = 2'd2; req_core = 4'd4; req_offset = 12'h044;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (20) @(negedge clk);
        chk(!req_ready && !rsp_valid && !bp_valid, "R10 stalled while switching",
            {29'h0, req_ready, rsp_valid, bp_valid}, 32'h0);
        begin
            int t;
            t = 0;
            while (!rsp_valid && t < 5000) begin
                @(negedge clk);
                t++;
            end
            chk(rsp_valid && rsp_rdata == (32'hC0DE_0000 ^ win_of(4'd4) ^ 32'h044),
                "R10 stalled request completes", rsp_rdata, 32'hC0DE_0000 ^ win_of(4'd4) ^ 32'h044);
        end
        @(negedge clk);

        // R1: reset clears the sticky flag and the mapping record
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(!err_sticky && req_ready, "R1 sticky cleared by reset", {31'h0, err_sticky}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        w0 = wwr_cnt;
        d = '{1'b1, 1'b0, 2'd2, 4'd4, 12'h048, 32'h0, 4'd0, 1'b0, 4'd1, 1'b0};
        issue(d, got, seen);
        chk(wwr_cnt - w0 == 1, "R1 mapping forgotten after reset", 32'(wwr_cnt - w0), 32'h1);
        chk(got == (32'hC0DE_0000 ^ win_of(4'd4) ^ 32'h048), "R9 read after reset",
            got, 32'hC0DE_0000 ^ win_of(4'd4) ^ 32'h048);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule